// File: doc/BRIEF.md
# Control Word Integration Detector

This block cleans up the per-frame control word and the four per-channel paid-broadcast flags of a digital audio downlink before they reach software and the mute logic. Each frame delivers a fresh 16-bit control word and four flag bits, any of which may be corrupted by a poor link. The block votes on every bit independently across a window of frames. It publishes a bit only when one value wins decisively, and keeps the earlier value when the vote is split.

Each counting cycle spans a fixed number of synchronous frames. The first `WINDOW` frames feed the per-bit tallies, and the remaining frames only pad the cycle. On the last frame of the cycle the decision is taken, the result is registered and the tallies are cleared. Frames that arrive while the link reports loss of synchronisation are skipped entirely. The filtered word drives three mute conditions and is also presented as two byte-wide register images for a host read port.

Top module: `ctrl_word_integrator`

## Requirements
- R1: After reset, `ctrlOut`, `chgOut`, both read bytes and all three mute outputs are 0.
- R2: A bit whose input was 1 in at least `THRESH` (12) of the `WINDOW` (15) counted window frames is published as 1.
- R3: A bit whose input was 0 in at least 12 of the 15 window frames is published as 0.
- R4: A bit with 4 to 11 ones in the window keeps its previously published value.
- R5: Results are published once every `PERIOD` (18) counted frames. Frames 16 to 18 of a cycle do not enter the vote. Outputs change only on the clock edge that accepts the 18th frame.
- R6: A strobe with `asyncFlag` high is not counted. It neither advances the cycle nor enters the vote.
- R7: Each of the four `chgIn` bits (bit c = channel c+1) goes through the same vote on its own.
- R8: `muteNoBcast` equals filtered control bit 7 (`ctrlOut[6]`). `muteSuppress` equals filtered control bit 16 (`ctrlOut[15]`). Control bit k is carried on `ctrlIn[k-1]`.
- R9: `muteNonAudio` is 1 exactly when filtered bits 2 and 3 (`ctrlOut[1]`, `ctrlOut[2]`) are both 1, or when bits 4 and 5 (`ctrlOut[3]`, `ctrlOut[4]`) are both 1.
- R10: `rdByteHi` holds filtered bits 1..8 with bit 1 in position 7. `rdByteLo` holds bits 9..16 with bit 9 in position 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | One-cycle strobe: a new frame's word and flags are present |
| asyncFlag | input | 1 | High while frame sync is lost |
| ctrlIn | input | 16 | Raw control word; control bit k on bit k-1 |
| chgIn | input | 4 | Raw per-channel paid-broadcast flags |
| ctrlOut | output | 16 | Filtered control word |
| chgOut | output | 4 | Filtered per-channel flags |
| rdByteHi | output | 8 | Register image of filtered bits 1..8, bit 1 at MSB |
| rdByteLo | output | 8 | Register image of filtered bits 9..16, bit 9 at MSB |
| muteNoBcast | output | 1 | Non-broadcast mute cause |
| muteSuppress | output | 1 | Audio-suppression mute cause |
| muteNonAudio | output | 1 | Non-audio-mode mute cause |

## Verification
The bench targets the exact vote boundaries: 12 of 15 must decide and 11 of 15 must hold. A design with an off-by-one threshold flips or freezes bits at those counts. The padding frames carry the complement of the expected result, so a design that counts them into the vote or publishes early fails the check made just before the 18th frame. Strobes with sync lost are mixed into a cycle, and a design that counts them publishes after the wrong frame. Words with deliberately chosen bit patterns expose swapped mute pairs and a reversed read-byte order.

// File: rtl/cwi_pkg.sv
package cwi_pkg;
  localparam int CTRL_BITS = 16;

  typedef struct packed {
    logic take;     // frame enters the vote
    logic publish;  // decide, register, clear tallies
  } cwiStrobe_t;
endpackage

// File: rtl/cwi_ctrl.sv
module cwi_ctrl
  import cwi_pkg::*;
#(
  parameter int WINDOW = 15,
  parameter int PERIOD = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameValid,
  input  logic       asyncFlag,
  output cwiStrobe_t strobe
);
  localparam int FC_W = $clog2(PERIOD);
  localparam logic [FC_W-1:0] LAST_FRAME = FC_W'(PERIOD - 1);
  localparam logic [FC_W-1:0] WIN_END    = FC_W'(WINDOW);

  logic [FC_W-1:0] frameCnt;
  logic            goodFrame;

  assign goodFrame = frameValid && !asyncFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
    end else if (goodFrame) begin
      if (frameCnt == LAST_FRAME) frameCnt <= '0;
      else                        frameCnt <= frameCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.take    = goodFrame && (frameCnt < WIN_END);
    strobe.publish = goodFrame && (frameCnt == LAST_FRAME);
  end

  assert_cycle_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= LAST_FRAME);

  assert_take_publish_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.take && strobe.publish));

  assert_async_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && asyncFlag) |=> $stable(frameCnt));
endmodule

// File: rtl/cwi_datapath.sv
module cwi_datapath
  import cwi_pkg::*;
#(
  parameter int LANES  = 20,
  parameter int WINDOW = 15,
  parameter int THRESH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  cwiStrobe_t       strobe,
  input  logic [LANES-1:0] rawBits,
  output logic [LANES-1:0] heldBits
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] ONE_WIN  = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] ZERO_WIN = CNT_W'(WINDOW - THRESH);
  localparam logic [CNT_W-1:0] WIN_MAX  = CNT_W'(WINDOW);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [CNT_W-1:0] onesCnt;
    logic             heldBit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        onesCnt <= '0;
        heldBit <= 1'b0;
      end else if (strobe.publish) begin
        onesCnt <= '0;
        if (onesCnt >= ONE_WIN)       heldBit <= 1'b1;
        else if (onesCnt <= ZERO_WIN) heldBit <= 1'b0;
      end else if (strobe.take) begin
        onesCnt <= onesCnt + CNT_W'(rawBits[g]);
      end
    end

    assign heldBits[g] = heldBit;

    assert_tally_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
      onesCnt <= WIN_MAX);
  end

  assert_hold_between_publish_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.publish |=> $stable(heldBits));
endmodule

// File: rtl/ctrl_word_integrator.sv
module ctrl_word_integrator
  import cwi_pkg::*;
#(
  parameter int CHANS  = 4,
  parameter int WINDOW = 15,
  parameter int THRESH = 12,
  parameter int PERIOD = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameValid,
  input  logic                 asyncFlag,
  input  logic [CTRL_BITS-1:0] ctrlIn,
  input  logic [CHANS-1:0]     chgIn,
  output logic [CTRL_BITS-1:0] ctrlOut,
  output logic [CHANS-1:0]     chgOut,
  output logic [7:0]           rdByteHi,
  output logic [7:0]           rdByteLo,
  output logic                 muteNoBcast,
  output logic                 muteSuppress,
  output logic                 muteNonAudio
);
  localparam int LANES = CTRL_BITS + CHANS;

  cwiStrobe_t       strobe;
  logic [LANES-1:0] heldBits;

  cwi_ctrl #(.WINDOW(WINDOW), .PERIOD(PERIOD)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameValid(frameValid),
    .asyncFlag (asyncFlag),
    .strobe    (strobe)
  );

  cwi_datapath #(.LANES(LANES), .WINDOW(WINDOW), .THRESH(THRESH)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rawBits ({chgIn, ctrlIn}),
    .heldBits(heldBits)
  );

  assign ctrlOut = heldBits[CTRL_BITS-1:0];
  assign chgOut  = heldBits[LANES-1:CTRL_BITS];

  // register image: lowest-numbered control bit lands in the MSB
  for (genvar i = 0; i < 8; i++) begin : gByte
    assign rdByteHi[7-i] = ctrlOut[i];
    assign rdByteLo[7-i] = ctrlOut[8+i];
  end

  assign muteNoBcast  = ctrlOut[6];
  assign muteSuppress = ctrlOut[15];
  assign muteNonAudio = (ctrlOut[1] && ctrlOut[2]) || (ctrlOut[3] && ctrlOut[4]);

  assert_out_moves_on_frame_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(frameValid && !asyncFlag) |=> $stable({chgOut, ctrlOut}));
endmodule

// File: tb/sim_ctrl_word_integrator.sv
module sim_ctrl_word_integrator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameValid = 1'b0;
  logic        asyncFlag = 1'b0;
  logic [15:0] ctrlIn = '0;
  logic [3:0]  chgIn = '0;
  logic [15:0] ctrlOut;
  logic [3:0]  chgOut;
  logic [7:0]  rdByteHi, rdByteLo;
  logic        muteNoBcast, muteSuppress, muteNonAudio;

  int nChecks = 0;
  int nFails  = 0;
  logic [19:0] prevExp = '0;

  always #2.5 clk = ~clk;

  ctrl_word_integrator u0 (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .asyncFlag(asyncFlag),
    .ctrlIn(ctrlIn), .chgIn(chgIn), .ctrlOut(ctrlOut), .chgOut(chgOut),
    .rdByteHi(rdByteHi), .rdByteLo(rdByteLo), .muteNoBcast(muteNoBcast),
    .muteSuppress(muteSuppress), .muteNonAudio(muteNonAudio)
  );

  // {wordA, countA, wordB, padWord, expected}; vector = {chg[3:0], ctrl[15:0]}
  localparam logic [83:0] VEC [9] = '{
    {20'hFFFFF, 4'd15, 20'h00000, 20'h00000, 20'hFFFFF},
    {20'h00000, 4'd12, 20'hFFFFF, 20'hFFFFF, 20'h00000},
    {20'hFFFFF, 4'd12, 20'h00000, 20'h00000, 20'hFFFFF},
    {20'h00000, 4'd11, 20'hFFFFF, 20'h00000, 20'hFFFFF},
    {20'h00000, 4'd15, 20'hFFFFF, 20'hFFFFF, 20'h00000},
    {20'hFFFFF, 4'd11, 20'h00000, 20'hFFFFF, 20'h00000},
    {20'h3C5A9, 4'd13, 20'hC3A56, 20'hC3A56, 20'h3C5A9},
    {20'h12345, 4'd12, 20'hFFFFF, 20'hEDCBA, 20'h12345},
    {20'hF0F0F, 4'd8,  20'h0FF00, 20'hED0FA, 20'h12F05}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [19:0] v, input logic async);
    @(negedge clk);
    {chgIn, ctrlIn} = v;
    asyncFlag = async;
    frameValid = 1'b1;
    @(negedge clk);
    frameValid = 1'b0;
    asyncFlag = 1'b0;
    @(negedge clk);
  endtask

  task automatic runCycle(input logic [19:0] a, input int na, input logic [19:0] b,
                          input logic [19:0] pad, input logic [19:0] exp, input string req);
    for (int k = 0; k < 15; k++) sendFrame(k < na ? a : b, 1'b0);
    sendFrame(pad, 1'b0);
    sendFrame(pad, 1'b0);
    check({req, "/R5 before 18th frame"}, {12'h0, chgOut, ctrlOut}, {12'h0, prevExp});
    sendFrame(pad, 1'b0);
    check(req, {12'h0, chgOut, ctrlOut}, {12'h0, exp});
    prevExp = exp;
  endtask

  task automatic checkWord(input logic [15:0] w, input logic [7:0] hi, input logic [7:0] lo,
                           input logic nb, input logic sp, input logic na);
    runCycle({4'h0, w}, 15, 20'h0, {4'h0, w}, {4'h0, w}, "R2");
    check("R8 nonbroadcast", {31'h0, muteNoBcast}, {31'h0, nb});
    check("R8 suppress", {31'h0, muteSuppress}, {31'h0, sp});
    check("R9 nonaudio", {31'h0, muteNonAudio}, {31'h0, na});
    check("R10 byte hi", {24'h0, rdByteHi}, {24'h0, hi});
    check("R10 byte lo", {24'h0, rdByteLo}, {24'h0, lo});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", {12'h0, chgOut, ctrlOut}, 32'h0);
    check("R1 bytes", {16'h0, rdByteHi, rdByteLo}, 32'h0);
    check("R1 mutes", {29'h0, muteNoBcast, muteSuppress, muteNonAudio}, 32'h0);

    // table: R2 R3 R4 R5, chg lanes R7 included
    for (int e = 0; e < 9; e++) begin
      runCycle(VEC[e][83:64], int'(VEC[e][63:60]), VEC[e][59:40], VEC[e][39:20],
               VEC[e][19:0], "R2/R3/R4/R7 table");
    end

    // R6: unsynchronised strobes interleaved with 12 ones and 3 zeros
    for (int k = 0; k < 12; k++) begin
      sendFrame(20'hFFFFF, 1'b0);
      if (k < 10) sendFrame(20'h00000, 1'b1);
    end
    for (int k = 0; k < 5; k++) sendFrame(20'h00000, 1'b0);
    check("R6 async not counted (hold)", {12'h0, chgOut, ctrlOut}, {12'h0, prevExp});
    sendFrame(20'h00000, 1'b0);
    check("R6 async not counted (publish)", {12'h0, chgOut, ctrlOut}, 32'h000FFFFF);
    prevExp = 20'hFFFFF;

    // R8 R9 R10 patterns
    checkWord(16'h0046, 8'h62, 8'h00, 1'b1, 1'b0, 1'b1);
    checkWord(16'h8018, 8'h18, 8'h01, 1'b0, 1'b1, 1'b1);
    checkWord(16'h000A, 8'h50, 8'h00, 1'b0, 1'b0, 1'b0);

    // R7: channels independent
    runCycle(20'hA0000, 15, 20'h0, 20'h50000, 20'hA0000, "R7 channels");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule